// File: doc/BRIEF.md
# Pair fault classifier

This block turns the outcome of a single-pair reflectometry run into a verdict. The verdict is healthy, open or shorted within the pair. It takes five inputs: the amplitudes of the strongest positive and negative echo peaks, the arrival time of each peak, and the receiver gain index. Each time arrives packed as a coarse cycle count and a fine phase. The block converts both times to one linear phase scale. It then decides which peak arrived later and whether the gap between the peaks falls inside a fixed acceptance window.

An amplitude gate stands in front of the verdict. A fault is reported only when both peaks rise above the noise floor and the gain index is non-negative. In every other case the result is healthy. A one-cycle start strobe captures the inputs. A two-bit code and a one-cycle valid pulse follow two clocks later. The code register keeps its value until the next classification.

Top module: `pair_fault_classifier`

## Requirements
- R1: While reset is asserted, and after it is released, `valid_o` is 0 and `result_o` is 0 (healthy) until the first classification.
- R2: The inputs are sampled on the rising edge where `start_i` is 1. `valid_o` is then 1 for exactly one cycle, starting at the second rising edge after the sampling edge. `valid_o` is never 1 otherwise.
- R3: Each 14-bit peak-time word carries a cycle count in bits 13:7 and a phase in bits 6:0. Its linear time is cycle*96 + phase. Phase values from 96 to 127 are added unchanged.
- R4: When the negative peak's linear time exceeds the positive peak's by D, and 96 <= D < 185, the code is 1 (open), provided the amplitude gate passes.
- R5: When the positive peak's linear time exceeds the negative peak's by D, and 96 <= D < 185, the code is 2 (same-pair short), provided the amplitude gate passes.
- R6: A separation of 95 or less, or of 185 or more, gives code 0 (healthy) in either ordering. A separation of 96 or 184 gives a fault.
- R7: The amplitude gate passes only when both amplitudes are strictly greater than 20 and bit 15 of the gain index (two's-complement sign) is 0. When the gate fails, the code is 0.
- R8: Equal linear peak times give code 0.
- R9: The codes are 0 healthy, 1 open and 2 short. Code 3 never appears on `result_o`.
- R10: A start on every cycle is accepted. Each start produces its own valid pulse and code, in order, two cycles later.
- R11: Input changes without `start_i` have no effect. `result_o` keeps the last code until the next valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Sample-and-classify strobe |
| pos_amp_i | input | 16 | Positive peak amplitude, unsigned |
| neg_amp_i | input | 16 | Negative peak amplitude, unsigned |
| pos_time_i | input | 14 | Packed positive peak time (cycle 13:7, phase 6:0) |
| neg_time_i | input | 14 | Packed negative peak time (cycle 13:7, phase 6:0) |
| gain_idx_i | input | 16 | Receiver gain index, two's complement |
| result_o | output | 2 | Classification code: 0 healthy, 1 open, 2 short |
| valid_o | output | 1 | One-cycle pulse marking a new code |

## Verification
A wrong internal state shows up at the ports within the valid pulse of the classification it affects. Three kinds of error are covered. A bad linear-time conversion moves a separation across a window edge. A wrong sign or width in the subtraction swaps open and short, or lets a reversed ordering pass as in-window. A stale gate flag lets a weak echo report a fault. The window edges at 95, 96, 184 and 185 are driven directly, as are phases above 95 and cycles near full scale, so an off-by-one or a field slip changes a code at once. A lost stage enable shows up in two ways: at the very next pulse during back-to-back starts, or as a drifting code while inputs change with no start.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    PFC_OK    = 2'd0,
    PFC_OPEN  = 2'd1,
    PFC_SHORT = 2'd2
  } pfc_code_e;

endpackage

// File: rtl/pfc_time_lin.sv
// Converts a packed cycle/phase peak time into a linear phase count.
module pfc_time_lin #(
  parameter int CYC_W      = 7,
  parameter int PH_W       = 7,
  parameter int PH_PER_CYC = 96,
  parameter int LIN_W      = 14
) (
  input  logic [CYC_W+PH_W-1:0] packed_i,
  output logic [LIN_W-1:0]      lin_o
);

  logic [CYC_W-1:0] cyc;
  logic [PH_W-1:0]  ph;

  always_comb begin
    cyc   = packed_i[CYC_W+PH_W-1:PH_W];
    ph    = packed_i[PH_W-1:0];
    lin_o = LIN_W'(cyc) * LIN_W'(PH_PER_CYC) + LIN_W'(ph);
  end

endmodule

// File: rtl/pfc_noise_gate.sv
// Passes only when both echoes clear the noise floor and the gain is non-negative.
module pfc_noise_gate #(
  parameter int AMP_W  = 16,
  parameter int GAIN_W = 16,
  parameter int NOISE  = 20
) (
  input  logic [AMP_W-1:0]  pos_amp_i,
  input  logic [AMP_W-1:0]  neg_amp_i,
  input  logic [GAIN_W-1:0] gain_i,
  output logic              pass_o
);

  localparam logic [AMP_W-1:0] NOISE_V = AMP_W'(NOISE);

  always_comb begin
    pass_o = (pos_amp_i > NOISE_V) && (neg_amp_i > NOISE_V) && !gain_i[GAIN_W-1];
  end

endmodule

// File: rtl/pfc_order_window.sv
// Decides fault type from peak ordering and separation window.
module pfc_order_window
  import pfc_pkg::*;
#(
  parameter int LIN_W    = 14,
  parameter int MIN_SEP  = 96,
  parameter int SEP_SPAN = 89,
  parameter int JITTER   = 30,
  parameter int HYB_REF  = 0
) (
  input  logic [LIN_W-1:0] pos_lin_i,
  input  logic [LIN_W-1:0] neg_lin_i,
  input  logic             gate_i,
  output pfc_code_e        code_o
);

  localparam int DIFF_W = LIN_W + 2;
  localparam logic signed [DIFF_W-1:0] MIN_S = DIFF_W'(MIN_SEP);
  localparam logic signed [DIFF_W-1:0] MAX_S = DIFF_W'(MIN_SEP + SEP_SPAN);
  localparam logic signed [DIFF_W-1:0] JIT_S = DIFF_W'(JITTER);
  localparam logic signed [DIFF_W-1:0] HYB_S = DIFF_W'(HYB_REF);

  logic signed [DIFF_W-1:0] p_s, n_s, d_pn, d_np;
  logic win_pn, win_np, short_hit, open_hit;

  always_comb begin
    p_s  = signed'({2'b00, pos_lin_i});
    n_s  = signed'({2'b00, neg_lin_i});
    d_pn = p_s - n_s;
    d_np = n_s - p_s;

    win_pn = (d_pn >= MIN_S) && (d_pn < MAX_S);
    win_np = (d_np >= MIN_S) && (d_np < MAX_S);

    short_hit = (p_s > n_s) && win_pn && (HYB_S < p_s) && (HYB_S < n_s + JIT_S);
    open_hit  = (n_s > p_s) && win_np && (HYB_S < n_s) && (HYB_S < p_s + JIT_S);

    code_o = PFC_OK;
    if (gate_i) begin
      if (short_hit)     code_o = PFC_SHORT;
      else if (open_hit) code_o = PFC_OPEN;
    end
  end

endmodule

// File: rtl/pair_fault_classifier.sv
// Two-stage pair fault classifier: linearize/gate, then order/window decision.
module pair_fault_classifier
  import pfc_pkg::*;
#(
  parameter int AMP_W      = 16,
  parameter int GAIN_W     = 16,
  parameter int CYC_W      = 7,
  parameter int PH_W       = 7,
  parameter int PH_PER_CYC = 96,
  parameter int MIN_SEP    = 96,
  parameter int SEP_SPAN   = 89,
  parameter int JITTER     = 30,
  parameter int NOISE      = 20,
  parameter int HYB_REF    = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [AMP_W-1:0]       pos_amp_i,
  input  logic [AMP_W-1:0]       neg_amp_i,
  input  logic [CYC_W+PH_W-1:0]  pos_time_i,
  input  logic [CYC_W+PH_W-1:0]  neg_time_i,
  input  logic [GAIN_W-1:0]      gain_idx_i,
  output logic [1:0]             result_o,
  output logic                   valid_o
);

  localparam int TIME_W  = CYC_W + PH_W;
  localparam int LIN_MAX = (2**CYC_W - 1) * PH_PER_CYC + (2**PH_W - 1);
  localparam int LIN_W   = $clog2(LIN_MAX + 1);

  // stage 1: linear times and gate
  logic [TIME_W-1:0] time_in [2];
  logic [LIN_W-1:0]  lin_d   [2];
  logic              gate_d;

  assign time_in[0] = pos_time_i;
  assign time_in[1] = neg_time_i;

  for (genvar g = 0; g < 2; g++) begin : g_lin
    pfc_time_lin #(
      .CYC_W(CYC_W), .PH_W(PH_W), .PH_PER_CYC(PH_PER_CYC), .LIN_W(LIN_W)
    ) i_lin (
      .packed_i(time_in[g]),
      .lin_o   (lin_d[g])
    );
  end

  pfc_noise_gate #(.AMP_W(AMP_W), .GAIN_W(GAIN_W), .NOISE(NOISE)) i_gate (
    .pos_amp_i(pos_amp_i),
    .neg_amp_i(neg_amp_i),
    .gain_i   (gain_idx_i),
    .pass_o   (gate_d)
  );

  logic [LIN_W-1:0] pos_lin_q, neg_lin_q, pos_lin_n, neg_lin_n;
  logic             gate_q, gate_n, vld1_q;

  always_comb begin
    pos_lin_n = pos_lin_q;
    neg_lin_n = neg_lin_q;
    gate_n    = gate_q;
    if (start_i) begin
      pos_lin_n = lin_d[0];
      neg_lin_n = lin_d[1];
      gate_n    = gate_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_lin_q <= '0;
      neg_lin_q <= '0;
      gate_q    <= 1'b0;
      vld1_q    <= 1'b0;
    end else begin
      pos_lin_q <= pos_lin_n;
      neg_lin_q <= neg_lin_n;
      gate_q    <= gate_n;
      vld1_q    <= start_i;
    end
  end

  // stage 2: ordering and window decision
  pfc_code_e code_d;

  pfc_order_window #(
    .LIN_W(LIN_W), .MIN_SEP(MIN_SEP), .SEP_SPAN(SEP_SPAN),
    .JITTER(JITTER), .HYB_REF(HYB_REF)
  ) i_win (
    .pos_lin_i(pos_lin_q),
    .neg_lin_i(neg_lin_q),
    .gate_i   (gate_q),
    .code_o   (code_d)
  );

  logic [1:0] res_q, res_n;
  logic       vld2_q;

  always_comb begin
    res_n = res_q;
    if (vld1_q) res_n = code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= 2'd0;
      vld2_q <= 1'b0;
    end else begin
      res_q  <= res_n;
      vld2_q <= vld1_q;
    end
  end

  assign result_o = res_q;
  assign valid_o  = vld2_q;

  // assertions
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> ##2 valid_o);                                        // R2
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(start_i, 2));                                  // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(result_o));                                 // R11
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    result_o != 2'd3);                                               // R9
  AST_GATE_FORCES_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1_q && !gate_q) |=> (result_o == PFC_OK));                   // R7
  AST_OPEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1_q && code_d == PFC_OPEN) |-> (neg_lin_q > pos_lin_q));     // R4
  AST_SHORT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (vld1_q && code_d == PFC_SHORT) |-> (pos_lin_q > neg_lin_q));    // R5

endmodule

// File: tb/test_pair_fault_classifier.sv
module test_pair_fault_classifier;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [15:0] pos_amp_i, neg_amp_i, gain_idx_i;
  logic [13:0] pos_time_i, neg_time_i;
  logic [1:0]  result_o;
  logic        valid_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  pair_fault_classifier i_pair_fault_classifier (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .pos_amp_i(pos_amp_i), .neg_amp_i(neg_amp_i),
    .pos_time_i(pos_time_i), .neg_time_i(neg_time_i),
    .gain_idx_i(gain_idx_i), .result_o(result_o), .valid_o(valid_o)
  );

  function automatic logic [13:0] pk(int cyc, int ph);
    return {7'(cyc), 7'(ph)};
  endfunction

  function automatic int lin(logic [13:0] t);
    return int'(t[13:7]) * 96 + int'(t[6:0]);
  endfunction

  function automatic logic [1:0] model(logic [15:0] pa, logic [15:0] na,
                                       logic [13:0] pt, logic [13:0] nt,
                                       logic [15:0] g);
    int p = lin(pt);
    int n = lin(nt);
    bit gate = (int'(pa) > 20) && (int'(na) > 20) && (g[15] == 1'b0);
    if (!gate) return 2'd0;
    if (p - n >= 96 && p - n < 185) return 2'd2;
    if (n - p >= 96 && n - p < 185) return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic [15:0] pa, logic [15:0] na, logic [13:0] pt,
                       logic [13:0] nt, logic [15:0] g, logic st);
    pos_amp_i = pa; neg_amp_i = na; pos_time_i = pt; neg_time_i = nt;
    gain_idx_i = g; start_i = st;
  endtask

  // one classification with full timing checks
  task automatic run_one(string req, logic [15:0] pa, logic [15:0] na,
                         logic [13:0] pt, logic [13:0] nt, logic [15:0] g);
    logic [1:0] e = model(pa, na, pt, nt, g);
    @(negedge clk);
    drive(pa, na, pt, nt, g, 1'b1);
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    chk({req, " R2 no early valid"}, int'(valid_o), 0);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R2 valid"}, int'(valid_o), 1);
    chk({req, " code"}, int'(result_o), int'(e));
    chk({req, " R9 legal"}, int'(result_o != 2'd3), 1);
    @(posedge clk);
    @(negedge clk);
    chk({req, " R2 one-cycle pulse"}, int'(valid_o), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0] exp_q [8];
    logic [13:0] pt_v [8];
    logic [13:0] nt_v [8];
    void'($urandom(32'd4242));
    rst_n = 1'b0;
    drive(16'd50, 16'd50, pk(1, 0), pk(2, 0), 16'd0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", int'(valid_o), 0);
    chk("R1 code in reset", int'(result_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", int'(valid_o), 0);
    chk("R1 code after reset", int'(result_o), 0);

    // R4 / R6 open window edges
    run_one("R4 R6 open d=96",  16'd50, 16'd50, pk(1, 0), pk(2, 0),  16'd0);
    run_one("R4 R6 open d=184", 16'd50, 16'd50, pk(0, 0), pk(1, 88), 16'd0);
    run_one("R6 open d=185",    16'd50, 16'd50, pk(0, 0), pk(1, 89), 16'd0);
    run_one("R6 open d=95",     16'd50, 16'd50, pk(0, 1), pk(1, 0),  16'd0);
    // R5 / R6 short window edges
    run_one("R5 R6 short d=96",  16'd50, 16'd50, pk(3, 10), pk(2, 10), 16'd0);
    run_one("R5 R6 short d=184", 16'd50, 16'd50, pk(2, 88), pk(1, 0),  16'd0);
    run_one("R6 short d=185",    16'd50, 16'd50, pk(2, 89), pk(1, 0),  16'd0);
    run_one("R6 short d=95",     16'd50, 16'd50, pk(1, 0),  pk(0, 1),  16'd0);
    // R3 phase above 95 and full-scale cycles
    run_one("R3 phase120 d=92",  16'd50, 16'd50, pk(0, 120), pk(2, 20), 16'd0);
    run_one("R3 phase120 d=102", 16'd50, 16'd50, pk(0, 120), pk(2, 30), 16'd0);
    run_one("R3 cycle127 short", 16'd50, 16'd50, pk(127, 0), pk(126, 0), 16'd0);
    // R8 equal times
    run_one("R8 equal", 16'd50, 16'd50, pk(5, 40), pk(5, 40), 16'd0);
    // R7 gate
    run_one("R7 pos amp 20",  16'd20, 16'd50, pk(1, 0), pk(2, 0), 16'd0);
    run_one("R7 neg amp 20",  16'd50, 16'd20, pk(1, 0), pk(2, 0), 16'd0);
    run_one("R7 amps 21",     16'd21, 16'd21, pk(1, 0), pk(2, 0), 16'd0);
    run_one("R7 gain neg",    16'd50, 16'd50, pk(1, 0), pk(2, 0), 16'h8000);
    run_one("R7 gain max pos",16'd50, 16'd50, pk(3, 10), pk(2, 10), 16'h7FFF);

    // R11 hold: last code is open; change inputs without start
    run_one("R11 setup open", 16'd50, 16'd50, pk(1, 0), pk(2, 0), 16'd0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      drive(16'd90, 16'd90, pk(3, 10), pk(2, 10), 16'd0, 1'b0);
      @(posedge clk);
      @(negedge clk);
      chk("R11 no valid", int'(valid_o), 0);
      chk("R11 code held", int'(result_o), 1);
    end

    // R10 back-to-back starts
    pt_v[0] = pk(1, 0);  nt_v[0] = pk(2, 0);
    pt_v[1] = pk(3, 10); nt_v[1] = pk(2, 10);
    pt_v[2] = pk(4, 4);  nt_v[2] = pk(4, 4);
    pt_v[3] = pk(0, 0);  nt_v[3] = pk(1, 88);
    pt_v[4] = pk(9, 50); nt_v[4] = pk(8, 50);
    pt_v[5] = pk(2, 0);  nt_v[5] = pk(0, 0);
    pt_v[6] = pk(6, 1);  nt_v[6] = pk(7, 0);
    pt_v[7] = pk(7, 0);  nt_v[7] = pk(8, 20);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk("R10 pipelined valid", int'(valid_o), 1);
        chk("R10 pipelined code", int'(result_o), int'(exp_q[i-2]));
      end
      if (i < 8) begin
        exp_q[i] = model(16'd40, 16'd40, pt_v[i], nt_v[i], 16'd3);
        drive(16'd40, 16'd40, pt_v[i], nt_v[i], 16'd3, 1'b1);
      end else begin
        start_i = 1'b0;
      end
      @(posedge clk);
    end

    // random mix
    for (int k = 0; k < 300; k++) begin
      int pc = $urandom_range(2, 124);
      int nc = pc + $urandom_range(0, 4) - 2;
      logic [15:0] pa = 16'($urandom_range(10, 60));
      logic [15:0] na = 16'($urandom_range(10, 60));
      logic [15:0] g  = ($urandom_range(0, 7) == 0) ? 16'($urandom_range(32768, 65535))
                                                    : 16'($urandom_range(0, 32767));
      run_one("R4 R5 R7 random", pa, na,
              pk(pc, $urandom_range(0, 127)), pk(nc, $urandom_range(0, 127)), g);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule